// File: doc/BRIEF.md
# Serial Channel Modem and DMA Pin Controller

This block produces the active-low modem-control and DMA-handshake pins of one serial channel. Configuration arrives as static bits from the channel's register file. Transmitter and receiver activity arrives as levels or one-cycle strobes: transmit buffer empty, closing flag shifted out, sync/flag detected and transmitter enabled. From these the block builds the request-to-send pin, the shared data-terminal-ready/DMA-request pin, the wait/request pin and the bidirectional sync pin. It also turns the sync pin, when it is an input, into a status level and a change pulse.

Every output is registered on the channel clock. Open-drain behaviour is modelled as a drive-enable together with a pad value held at 0. The DMA-request role of the shared pin can drop either on the next edge or after a fixed hold of `HOLD_CYC` edges.

Top module: `modem_pin_ctrl`

## Requirements
- R1: While rst_ni is low and after its release until inputs change: rts_no=1, dtr_req_no=1, wreq_no=0 with wreq_oe_o=0 (wait function, released), sync_no=1, sync_oe_o=0, sync_stat_o=1, sync_chg_o=0.
- R2: When deferral is not active, rts_no equals the inverse of rts_bit_i one clock edge later. Deferral is active only when auto_en_i=1, mode_i=2 (SDLC) and rts_defer_i=1.
- R3: With deferral active, RTS asserted and rts_bit_i low, rts_no stays 0 until an edge sees tx_flag_done_i=1; it rises after that edge. An edge with rts_bit_i=1 re-asserts RTS.
- R4: With req_role_i=0, dtr_req_no equals the inverse of dtr_bit_i one edge later.
- R5: With req_role_i=1, an edge that sees tx_empty_i=1 drives dtr_req_no to 0.
- R6: With req_role_i=1 and req_fast_i=1, the first edge that sees tx_empty_i=0 drives dtr_req_no to 1, the same timing as wait/request.
- R7: With req_role_i=1 and req_fast_i=0, dtr_req_no rises on the fourth edge that sees tx_empty_i=0 (HOLD_CYC=4). A new empty indication restarts the hold.
- R8: In wait function (wreq_fn_i=0), wreq_no is 0 and wreq_oe_o is 1 exactly when wreq_en_i=1 and tx_empty_i=0 at the previous edge.
- R9: In request function (wreq_fn_i=1), wreq_oe_o is 1 and wreq_no is the inverse of (wreq_en_i and tx_empty_i) at the previous edge.
- R10: sync_oe_o is 1 one edge after sync_en_i=1 with mode_i=1 (character sync) or mode_i=2 (SDLC). Modes 0 (asynchronous) and 3 (external sync) leave it 0 and sync_no at 1.
- R11: As an output, sync_no is 0 for exactly the cycle after each edge that sees sync_det_i=1.
- R12: When the sync pin is an input, sync_stat_o takes the sync_pin_i level on the third edge after it changes, and sync_chg_o pulses for that one cycle. The pin has no effect on any other output. When the pin is an output, status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Automatic enables on |
| rts_bit_i | input | 1 | RTS control bit from register file |
| rts_defer_i | input | 1 | Defer RTS drop until closing flag clears |
| dtr_bit_i | input | 1 | DTR control bit |
| req_role_i | input | 1 | Shared pin role: 0 DTR, 1 transmit DMA request |
| req_fast_i | input | 1 | Request drops with wait/request timing |
| wreq_fn_i | input | 1 | Wait/request function: 0 wait, 1 request |
| wreq_en_i | input | 1 | Wait/request function enabled |
| mode_i | input | 2 | 0 async, 1 char sync, 2 SDLC, 3 external sync |
| sync_en_i | input | 1 | Sync modes enabled |
| tx_empty_i | input | 1 | Transmit buffer empty level |
| tx_flag_done_i | input | 1 | Strobe: closing flag fully shifted out |
| sync_det_i | input | 1 | Strobe: sync pattern or flag recognised |
| tx_en_i | input | 1 | Transmitter enabled; RTS re-assert needs it in deferral mode |
| sync_pin_i | input | 1 | Sync pad input level |
| rts_no | output | 1 | Request to send, active low |
| dtr_req_no | output | 1 | DTR or DMA request, active low |
| wreq_no | output | 1 | Wait/request pad value, active low |
| wreq_oe_o | output | 1 | Wait/request drive enable |
| sync_no | output | 1 | Sync pad output value, active low |
| sync_oe_o | output | 1 | Sync pad drive enable |
| sync_stat_o | output | 1 | Synchronised sync input level |
| sync_chg_o | output | 1 | One-cycle pulse on a status change |

## Verification
On every cycle the assertions check several properties. RTS follows its control bit when deferral is off, and it is held while a deferred drop awaits the flag strobe. The request pin is asserted while the buffer is empty, and it drops at once in fast mode. The wait function never drives the pad high, the sync pin is never driven in asynchronous or external modes, and every change pulse matches a status change. Only the bench scenarios can show the exact four-edge hold and its restart, the three-edge status latency, and the fact that the sync input leaves other pins untouched. Those come from cycle-counted sequences compared against a bench-side reference model.

// File: rtl/modem_pin_pkg.sv
package modem_pin_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'd0,
    MODE_CHARSYNC = 2'd1,
    MODE_SDLC     = 2'd2,
    MODE_EXTSYNC  = 2'd3
  } chan_mode_e;

  function automatic logic sync_is_output(input chan_mode_e m, input logic en);
    return en && (m == MODE_CHARSYNC || m == MODE_SDLC);
  endfunction
endpackage

// File: rtl/modem_rts_ctl.sv
module modem_rts_ctl
  import modem_pin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_en_i,
  input  chan_mode_e mode_i,
  input  logic       rts_bit_i,
  input  logic       rts_defer_i,
  input  logic       tx_flag_done_i,
  output logic       rts_no
);
  logic rts_act_q, past_vld_q;
  logic defer_act;

  assign defer_act = auto_en_i && (mode_i == MODE_SDLC) && rts_defer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_act_q  <= 1'b0;
      past_vld_q <= 1'b0;
    end else begin
      past_vld_q <= 1'b1;
      if (rts_bit_i)                   rts_act_q <= 1'b1;
      else if (!defer_act)             rts_act_q <= 1'b0;
      else if (tx_flag_done_i)         rts_act_q <= 1'b0;
    end
  end

  assign rts_no = ~rts_act_q;

  p_rts_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(!defer_act) |-> rts_no == !$past(rts_bit_i));

  p_rts_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(defer_act && !rts_no && !tx_flag_done_i) |-> !rts_no);
endmodule

// File: rtl/modem_req_ctl.sv
module modem_req_ctl #(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_role_i,
  input  logic req_fast_i,
  input  logic dtr_bit_i,
  input  logic wreq_fn_i,
  input  logic wreq_en_i,
  input  logic tx_empty_i,
  output logic dtr_req_no,
  output logic wreq_no,
  output logic wreq_oe_o
);
  localparam int unsigned CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

  logic             req_act_q, past_vld_q;
  logic [CNT_W-1:0] hold_q;
  logic             wreq_val_q, wreq_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_act_q  <= 1'b0;
      hold_q     <= '0;
      past_vld_q <= 1'b0;
    end else begin
      past_vld_q <= 1'b1;
      if (!req_role_i) begin
        req_act_q <= dtr_bit_i;
        hold_q    <= '0;
      end else if (tx_empty_i) begin
        req_act_q <= 1'b1;
        hold_q    <= RELOAD;  // restart hold on every empty indication
      end else if (req_fast_i) begin
        req_act_q <= 1'b0;
        hold_q    <= '0;
      end else if (req_act_q) begin
        if (hold_q == '0) req_act_q <= 1'b0;
        else              hold_q    <= hold_q - 1'b1;
      end
    end
  end

  // wait: open-drain pulled low while CPU must stall; request: push-pull
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wreq_val_q <= 1'b0;
      wreq_oe_q  <= 1'b0;
    end else if (!wreq_fn_i) begin
      wreq_val_q <= 1'b0;
      wreq_oe_q  <= wreq_en_i && !tx_empty_i;
    end else begin
      wreq_val_q <= !(wreq_en_i && tx_empty_i);
      wreq_oe_q  <= 1'b1;
    end
  end

  assign dtr_req_no = ~req_act_q;
  assign wreq_no    = wreq_val_q;
  assign wreq_oe_o  = wreq_oe_q;

  p_dtr_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(!req_role_i) |-> dtr_req_no == !$past(dtr_bit_i));

  p_req_assert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(req_role_i && tx_empty_i) |-> !dtr_req_no);

  p_req_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(req_role_i && !tx_empty_i && req_fast_i) |-> dtr_req_no);

  p_wait_od_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(!wreq_fn_i) |-> !wreq_no);

  p_req_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(wreq_fn_i) |-> wreq_oe_o);
endmodule

// File: rtl/modem_sync_ctl.sv
module modem_sync_ctl
  import modem_pin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  chan_mode_e mode_i,
  input  logic       sync_en_i,
  input  logic       sync_det_i,
  input  logic       sync_pin_i,
  output logic       sync_no,
  output logic       sync_oe_o,
  output logic       sync_stat_o,
  output logic       sync_chg_o
);
  logic                   out_mode;
  logic [SYNC_STAGES-1:0] meta_q;
  logic                   stat_q, chg_q, oe_q, val_q, past_vld_q;

  assign out_mode = sync_is_output(mode_i, sync_en_i);

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) meta_q <= '1;
        else         meta_q <= sync_pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) meta_q <= '1;
        else         meta_q <= {meta_q[SYNC_STAGES-2:0], sync_pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= 1'b1;
      chg_q      <= 1'b0;
      oe_q       <= 1'b0;
      val_q      <= 1'b1;
      past_vld_q <= 1'b0;
    end else begin
      past_vld_q <= 1'b1;
      oe_q       <= out_mode;
      val_q      <= out_mode ? !sync_det_i : 1'b1;
      if (!out_mode) begin
        stat_q <= meta_q[SYNC_STAGES-1];
        chg_q  <= meta_q[SYNC_STAGES-1] != stat_q;
      end else begin
        chg_q  <= 1'b0;
      end
    end
  end

  assign sync_no     = val_q;
  assign sync_oe_o   = oe_q;
  assign sync_stat_o = stat_q;
  assign sync_chg_o  = chg_q;

  p_sync_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(!out_mode) |-> !sync_oe_o && sync_no);

  p_sync_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(out_mode && sync_det_i) |-> !sync_no);

  p_chg_match_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && sync_chg_o |-> sync_stat_o != $past(sync_stat_o));
endmodule

// File: rtl/modem_pin_ctrl.sv
module modem_pin_ctrl
  import modem_pin_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_en_i,
  input  logic       rts_bit_i,
  input  logic       rts_defer_i,
  input  logic       dtr_bit_i,
  input  logic       req_role_i,
  input  logic       req_fast_i,
  input  logic       wreq_fn_i,
  input  logic       wreq_en_i,
  input  logic [1:0] mode_i,
  input  logic       sync_en_i,
  input  logic       tx_empty_i,
  input  logic       tx_flag_done_i,
  input  logic       sync_det_i,
  input  logic       tx_en_i,
  input  logic       sync_pin_i,
  output logic       rts_no,
  output logic       dtr_req_no,
  output logic       wreq_no,
  output logic       wreq_oe_o,
  output logic       sync_no,
  output logic       sync_oe_o,
  output logic       sync_stat_o,
  output logic       sync_chg_o
);
  chan_mode_e mode;
  logic       rts_req;

  assign mode = chan_mode_e'(mode_i);
  // in deferral mode a fresh assert needs the transmitter up
  assign rts_req = rts_bit_i && (tx_en_i || !(auto_en_i && rts_defer_i && mode == MODE_SDLC));

  modem_rts_ctl u_rts (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .auto_en_i      (auto_en_i),
    .mode_i         (mode),
    .rts_bit_i      (rts_req),
    .rts_defer_i    (rts_defer_i),
    .tx_flag_done_i (tx_flag_done_i),
    .rts_no         (rts_no)
  );

  modem_req_ctl #(.HOLD_CYC(HOLD_CYC)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_role_i (req_role_i),
    .req_fast_i (req_fast_i),
    .dtr_bit_i  (dtr_bit_i),
    .wreq_fn_i  (wreq_fn_i),
    .wreq_en_i  (wreq_en_i),
    .tx_empty_i (tx_empty_i),
    .dtr_req_no (dtr_req_no),
    .wreq_no    (wreq_no),
    .wreq_oe_o  (wreq_oe_o)
  );

  modem_sync_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .sync_en_i   (sync_en_i),
    .sync_det_i  (sync_det_i),
    .sync_pin_i  (sync_pin_i),
    .sync_no     (sync_no),
    .sync_oe_o   (sync_oe_o),
    .sync_stat_o (sync_stat_o),
    .sync_chg_o  (sync_chg_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |=> !rst_ni || (rts_no && dtr_req_no && !wreq_oe_o && !sync_oe_o));
endmodule

// File: tb/modem_pin_ctrl_test.sv
`timescale 1ns/1ps
module modem_pin_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_en = 0, rts_bit = 0, rts_defer = 0, dtr_bit = 0, req_role = 0, req_fast = 0;
  logic wreq_fn = 0, wreq_en = 0, sync_en = 0, tx_empty = 0, flag_done = 0, sync_det = 0;
  logic tx_en = 0, sync_pin = 1;
  logic [1:0] mode = 2'd0;
  logic rts_n, dtr_n, wreq_n, wreq_oe, sync_n, sync_oe, stat, chg;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic m_rts, m_req, m_wv, m_woe, m_sv, m_soe, m_s1, m_s2, m_stat, m_chg;
  int   m_cnt;

  always #5 clk = ~clk;

  modem_pin_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .auto_en_i(auto_en), .rts_bit_i(rts_bit),
    .rts_defer_i(rts_defer), .dtr_bit_i(dtr_bit), .req_role_i(req_role),
    .req_fast_i(req_fast), .wreq_fn_i(wreq_fn), .wreq_en_i(wreq_en), .mode_i(mode),
    .sync_en_i(sync_en), .tx_empty_i(tx_empty), .tx_flag_done_i(flag_done),
    .sync_det_i(sync_det), .tx_en_i(tx_en), .sync_pin_i(sync_pin),
    .rts_no(rts_n), .dtr_req_no(dtr_n), .wreq_no(wreq_n), .wreq_oe_o(wreq_oe),
    .sync_no(sync_n), .sync_oe_o(sync_oe), .sync_stat_o(stat), .sync_chg_o(chg)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic defer_on();
    return auto_en && mode == 2'd2 && rts_defer;
  endfunction

  function automatic logic out_mode();
    return sync_en && (mode == 2'd1 || mode == 2'd2);
  endfunction

  task automatic model_reset();
    m_rts = 0; m_req = 0; m_cnt = 0; m_wv = 0; m_woe = 0;
    m_sv = 1; m_soe = 0; m_s1 = 1; m_s2 = 1; m_stat = 1; m_chg = 0;
  endtask

  // advance model with current inputs, clock once, compare at negedge
  task automatic step();
    logic want, dfr, om;
    string rtag, dtag;
    dfr  = defer_on();
    om   = out_mode();
    want = rts_bit && (tx_en || !dfr);
    rtag = dfr ? "R3" : "R2";
    if (!req_role) dtag = "R4";
    else if (tx_empty) dtag = "R5";
    else if (req_fast) dtag = "R6";
    else dtag = "R7";
    if (want) m_rts = 1;
    else if (!dfr || flag_done) m_rts = 0;
    if (!req_role) begin m_req = dtr_bit; m_cnt = 0; end
    else if (tx_empty) begin m_req = 1; m_cnt = 3; end
    else if (req_fast) begin m_req = 0; m_cnt = 0; end
    else if (m_req) begin
      if (m_cnt == 0) m_req = 0; else m_cnt--;
    end
    if (!wreq_fn) begin m_wv = 0; m_woe = wreq_en && !tx_empty; end
    else begin m_wv = !(wreq_en && tx_empty); m_woe = 1; end
    m_soe = om;
    m_sv  = om ? !sync_det : 1'b1;
    if (!om) begin m_chg = (m_s2 != m_stat); m_stat = m_s2; end
    else m_chg = 0;
    m_s2 = m_s1;
    m_s1 = sync_pin;
    @(posedge clk);
    @(negedge clk);
    check(rtag, "rts_no", rts_n, !m_rts);
    check(dtag, "dtr_req_no", dtr_n, !m_req);
    check(wreq_fn ? "R9" : "R8", "wreq_no", wreq_n, m_wv);
    check(wreq_fn ? "R9" : "R8", "wreq_oe", wreq_oe, m_woe);
    check("R10", "sync_oe", sync_oe, m_soe);
    check("R11", "sync_no", sync_n, m_sv);
    check("R12", "sync_stat", stat, m_stat);
    check("R12", "sync_chg", chg, m_chg);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic rts_before, dtr_before;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "rts_no", rts_n, 1); check("R1", "dtr_req_no", dtr_n, 1);
    check("R1", "wreq_oe", wreq_oe, 0); check("R1", "wreq_no", wreq_n, 0);
    check("R1", "sync_oe", sync_oe, 0); check("R1", "sync_no", sync_n, 1);
    check("R1", "sync_stat", stat, 1); check("R1", "sync_chg", chg, 0);
    rst_n = 1;
    step();

    // R2: general-purpose RTS
    rts_bit = 1; step(); check("R2", "rts asserted", rts_n, 0);
    rts_bit = 0; step(); check("R2", "rts released", rts_n, 1);

    // R3: deferred drop until closing flag
    auto_en = 1; mode = 2'd2; rts_defer = 1; tx_en = 1; rts_bit = 1; step();
    rts_bit = 0; repeat (5) step();
    check("R3", "rts held awaiting flag", rts_n, 0);
    flag_done = 1; step(); flag_done = 0;
    check("R3", "rts dropped after flag", rts_n, 1);
    auto_en = 0; rts_defer = 0; mode = 2'd0;

    // R7: slow deassert, restart on new empty
    req_role = 1; req_fast = 0; tx_empty = 1; step();
    check("R5", "request on empty", dtr_n, 0);
    tx_empty = 0; step(); step(); step();
    check("R7", "held third edge", dtr_n, 0);
    tx_empty = 1; step(); tx_empty = 0; step(); step(); step();
    check("R7", "restart holds", dtr_n, 0);
    step(); check("R7", "drop fourth edge", dtr_n, 1);

    // R6: fast deassert
    req_fast = 1; tx_empty = 1; step(); tx_empty = 0; step();
    check("R6", "fast drop", dtr_n, 1);

    // R12: async input latency, no side effects
    req_role = 0; dtr_bit = 1; step(); step();
    rts_before = rts_n; dtr_before = dtr_n;
    sync_pin = 0; step(); step();
    check("R12", "stat not yet", stat, 1);
    step(); check("R12", "stat updated", stat, 0); check("R12", "chg pulse", chg, 1);
    step(); check("R12", "chg one cycle", chg, 0);
    check("R12", "rts untouched", rts_n, rts_before);
    check("R12", "dtr untouched", dtr_n, dtr_before);
    sync_pin = 1;

    // R10/R11: output in SDLC
    mode = 2'd2; sync_en = 1; step(); check("R10", "sync drives", sync_oe, 1);
    sync_det = 1; step(); sync_det = 0; check("R11", "sync pulse", sync_n, 0);
    step(); check("R11", "pulse ends", sync_n, 1);
    mode = 2'd3; step(); check("R10", "external is input", sync_oe, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(31) == 0) mode = 2'($urandom_range(3));
      if ($urandom_range(15) == 0) begin
        auto_en = 1'($urandom); rts_defer = 1'($urandom); sync_en = 1'($urandom);
        req_role = 1'($urandom); req_fast = 1'($urandom); wreq_fn = 1'($urandom);
      end
      if ($urandom_range(7) == 0) rts_bit = ~rts_bit;
      if ($urandom_range(7) == 0) tx_empty = ~tx_empty;
      if ($urandom_range(7) == 0) sync_pin = ~sync_pin;
      dtr_bit   = ($urandom_range(9) == 0) ? ~dtr_bit : dtr_bit;
      wreq_en   = ($urandom_range(9) == 0) ? ~wreq_en : wreq_en;
      tx_en     = ($urandom_range(9) == 0) ? ~tx_en : tx_en;
      flag_done = ($urandom_range(7) == 0);
      sync_det  = ($urandom_range(5) == 0);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule